// File: doc/BRIEF.md
# Whole-Cartridge Disk Read Sequencer

This block runs one transaction that copies a complete disk pack into RAM. Once started, it visits every sector address. The sector number changes fastest, then the head, then the cylinder. For each address it drives two lower-level engines through a fully interlocked handshake. The positioning engine moves the heads to a cylinder. The sector-read engine waits internally for its target sector to pass under the heads, then streams data words back.

Every handshake has four steps: raise the request, wait for completion, drop the request, and wait for completion to fall. This ordering absorbs the one-clock update latency of the control registers, so no request can overlap a stale completion from an earlier step.

Each word that arrives during a read goes to a RAM address built from two fields side by side: a running sector serial number and a word index within the sector. No offset arithmetic is used. The current cylinder, head, sector and sequencer state are visible on the outputs so the run can be watched.

Top module: `pack_archiver`

## Requirements
- R1: A synchronous reset makes `dbgState` 0 (idle) and drives `busy`, `done`, `seekStart`, `rdStart`, `seekCyl`, `rdHead`, `rdSect` and `ramAddr` to zero.
- R2: A `start` pulse while idle causes the following, visible one clock later: `busy` is high, `done` is low, all counters are zero, and `seekStart` is high with `seekCyl` 0.
- R3: `seekStart` stays high until `seekDone` is sampled high and falls on the next clock. The sequencer then waits for `seekDone` to be sampled low before doing anything else.
- R4: `rdStart` rises only after a clock at which `seekStart`, `seekDone` and `rdDone` were all low. It then follows the same rule as R3: it holds until `rdDone` is sampled high and falls one clock later. The two request lines are never high together.
- R5: Reads run with sector fastest, then head, then cylinder. When `rdStart` rises for the n-th time (counting from 0), `rdSect` = n mod NUM_SECT, `rdHead` = (n / NUM_SECT) mod NUM_HEAD, and `seekCyl` = n / (NUM_SECT*NUM_HEAD).
- R6: A positioning request is issued only when the cylinder changes, so exactly once per cylinder. It is issued before the first read of that cylinder, and `seekCyl` carries the new cylinder number.
- R7: `ramWe` equals `wordValid` while `rdStart` is high and is 0 otherwise. `ramData` equals `wordIn` in the same cycle. Words that arrive outside a read are dropped.
- R8: `ramAddr` = serial*WORDS + index. Here serial is the 0-based count of sectors read so far, and index counts the words already stored for this sector. It advances by exactly one per stored word and restarts at the next sector's base. A word that arrives in the same cycle as `rdDone` is still stored.
- R9: After the last sector's read handshake completes, `busy` falls and `done` rises. `done` stays high until the next accepted `start`.
- R10: A `start` pulse while busy has no effect: the transaction continues in order and `busy` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a whole-pack transaction (idle only) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Sticky completion flag |
| seekStart | output | 1 | Request to the positioning engine |
| seekCyl | output | CYL_W | Target cylinder / cylinder counter |
| seekDone | input | 1 | Positioning engine completion |
| rdStart | output | 1 | Request to the sector-read engine |
| rdHead | output | HEAD_W | Target head / head counter |
| rdSect | output | SECT_W | Target sector / sector counter |
| rdDone | input | 1 | Sector-read engine completion |
| wordValid | input | 1 | Data word strobe from the read engine |
| wordIn | input | DATA_W | Data word from the read engine |
| ramWe | output | 1 | RAM write enable |
| ramAddr | output | ADDR_W | RAM write address {serial, index} |
| ramData | output | DATA_W | RAM write data |
| dbgState | output | 3 | State: 0 idle, 1 seek request, 2 seek release, 3 read request, 4 read release, 5 step |

## Verification
Two events can land on the same clock edge: storing a sector's final word and the read engine raising its completion. The bench provokes this directly. One run always delivers full sectors and raises `rdDone` together with the last word. The random runs raise completion together with the last word about half the time.

Correct handling is judged at the RAM port. The coinciding word must be written at the next index. The following sector must start exactly at its own base address, whether or not the word index wrapped.

A second collision is a `start` pulse that arrives while a handshake is advancing. The bench judges this through unbroken sector ordering and a `busy` line that stays high.

// File: rtl/pack_archiver_pkg.sv
package pack_archiver_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SEEK_REQ = 3'd1,
    ST_SEEK_REL = 3'd2,
    ST_RD_REQ   = 3'd3,
    ST_RD_REL   = 3'd4,
    ST_STEP     = 3'd5
  } seqState_t;

  typedef struct packed {
    logic clrAll;
    logic stepAddr;
    logic storeWord;
  } dpCtl_t;

  function automatic int bitsFor(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/pack_archiver_ctrl.sv
module pack_archiver_ctrl
  import pack_archiver_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      start,
  input  logic      seekDone,
  input  logic      rdDone,
  input  logic      wordValid,
  input  logic      lastSect,
  input  logic      lastHead,
  input  logic      lastCyl,
  output dpCtl_t    ctl,
  output logic      seekStart,
  output logic      rdStart,
  output logic      busy,
  output logic      done,
  output seqState_t stateOut
);

  seqState_t state, stateNext;
  logic doneReg, doneSet;

  always_comb begin
    stateNext = state;
    ctl = '0;
    doneSet = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.clrAll = 1'b1;
          stateNext = ST_SEEK_REQ;
        end
      end
      ST_SEEK_REQ: if (seekDone) stateNext = ST_SEEK_REL;
      ST_SEEK_REL: if (!seekDone) stateNext = ST_RD_REQ;
      ST_RD_REQ: begin
        ctl.storeWord = wordValid;
        if (rdDone) stateNext = ST_RD_REL;
      end
      ST_RD_REL: if (!rdDone) stateNext = ST_STEP;
      ST_STEP: begin
        if (lastSect && lastHead && lastCyl) begin
          doneSet = 1'b1;
          stateNext = ST_IDLE;
        end else begin
          ctl.stepAddr = 1'b1;
          stateNext = (lastSect && lastHead) ? ST_SEEK_REQ : ST_RD_REQ;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state <= stateNext;
      if (doneSet) doneReg <= 1'b1;
      else if (ctl.clrAll) doneReg <= 1'b0;
    end
  end

  assign seekStart = (state == ST_SEEK_REQ);
  assign rdStart   = (state == ST_RD_REQ);
  assign busy      = (state != ST_IDLE);
  assign done      = doneReg;
  assign stateOut  = state;

endmodule

// File: rtl/pack_archiver_dp.sv
module pack_archiver_dp
  import pack_archiver_pkg::*;
#(
  parameter int NUM_CYL  = 203,
  parameter int NUM_HEAD = 2,
  parameter int NUM_SECT = 12,
  parameter int WORDS    = 256,
  localparam int CYL_W    = bitsFor(NUM_CYL),
  localparam int HEAD_W   = bitsFor(NUM_HEAD),
  localparam int SECT_W   = bitsFor(NUM_SECT),
  localparam int WORD_W   = bitsFor(WORDS),
  localparam int SERIAL_W = bitsFor(NUM_CYL * NUM_HEAD * NUM_SECT),
  localparam int ADDR_W   = SERIAL_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  output logic [CYL_W-1:0]  cyl,
  output logic [HEAD_W-1:0] head,
  output logic [SECT_W-1:0] sect,
  output logic              lastSect,
  output logic              lastHead,
  output logic              lastCyl,
  output logic [ADDR_W-1:0] ramAddr
);

  logic [SERIAL_W-1:0] serial;
  logic [WORD_W-1:0]   wordIdx;

  assign lastSect = (sect == SECT_W'(NUM_SECT - 1));
  assign lastHead = (head == HEAD_W'(NUM_HEAD - 1));
  assign lastCyl  = (cyl == CYL_W'(NUM_CYL - 1));

  always_ff @(posedge clk) begin
    if (rst || ctl.clrAll) begin
      cyl     <= '0;
      head    <= '0;
      sect    <= '0;
      serial  <= '0;
      wordIdx <= '0;
    end else if (ctl.stepAddr) begin
      serial  <= serial + 1'b1;
      wordIdx <= '0;
      if (lastSect) begin
        sect <= '0;
        if (lastHead) begin
          head <= '0;
          cyl  <= cyl + 1'b1;
        end else begin
          head <= head + 1'b1;
        end
      end else begin
        sect <= sect + 1'b1;
      end
    end else if (ctl.storeWord) begin
      wordIdx <= wordIdx + 1'b1;
    end
  end

  assign ramAddr = {serial, wordIdx};

endmodule

// File: rtl/pack_archiver.sv
module pack_archiver
  import pack_archiver_pkg::*;
#(
  parameter int NUM_CYL  = 203,
  parameter int NUM_HEAD = 2,
  parameter int NUM_SECT = 12,
  parameter int WORDS    = 256,
  parameter int DATA_W   = 16,
  localparam int CYL_W    = bitsFor(NUM_CYL),
  localparam int HEAD_W   = bitsFor(NUM_HEAD),
  localparam int SECT_W   = bitsFor(NUM_SECT),
  localparam int WORD_W   = bitsFor(WORDS),
  localparam int SERIAL_W = bitsFor(NUM_CYL * NUM_HEAD * NUM_SECT),
  localparam int ADDR_W   = SERIAL_W + WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              seekStart,
  output logic [CYL_W-1:0]  seekCyl,
  input  logic              seekDone,
  output logic              rdStart,
  output logic [HEAD_W-1:0] rdHead,
  output logic [SECT_W-1:0] rdSect,
  input  logic              rdDone,
  input  logic              wordValid,
  input  logic [DATA_W-1:0] wordIn,
  output logic              ramWe,
  output logic [ADDR_W-1:0] ramAddr,
  output logic [DATA_W-1:0] ramData,
  output logic [2:0]        dbgState
);

  dpCtl_t    ctl;
  seqState_t state;
  logic      lastSect, lastHead, lastCyl;

  pack_archiver_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .seekDone  (seekDone),
    .rdDone    (rdDone),
    .wordValid (wordValid),
    .lastSect  (lastSect),
    .lastHead  (lastHead),
    .lastCyl   (lastCyl),
    .ctl       (ctl),
    .seekStart (seekStart),
    .rdStart   (rdStart),
    .busy      (busy),
    .done      (done),
    .stateOut  (state)
  );

  pack_archiver_dp #(
    .NUM_CYL  (NUM_CYL),
    .NUM_HEAD (NUM_HEAD),
    .NUM_SECT (NUM_SECT),
    .WORDS    (WORDS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .cyl      (seekCyl),
    .head     (rdHead),
    .sect     (rdSect),
    .lastSect (lastSect),
    .lastHead (lastHead),
    .lastCyl  (lastCyl),
    .ramAddr  (ramAddr)
  );

  assign ramWe    = ctl.storeWord;
  assign ramData  = wordIn;
  assign dbgState = state;

endmodule

// File: rtl/pack_archiver_chk.sv
module pack_archiver_chk #(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              seekStart,
  input logic              seekDone,
  input logic              rdStart,
  input logic              rdDone,
  input logic              ramWe,
  input logic [ADDR_W-1:0] ramAddr,
  input logic [2:0]        dbgState
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (dbgState == 3'd0 && !seekStart && !rdStart && !busy && !done));

  p_seek_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (seekStart && !seekDone) |=> seekStart);

  p_seek_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (seekStart && seekDone) |=> !seekStart);

  p_rd_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (rdStart && rdDone) |=> !rdStart);

  p_rd_clean_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(rdStart) |-> $past(!seekStart && !seekDone && !rdDone));

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (rst)
    !(seekStart && rdStart));

  p_store_in_read_r7: assert property (@(posedge clk) disable iff (rst)
    ramWe |-> rdStart);

  p_index_step_r8: assert property (@(posedge clk) disable iff (rst)
    ramWe |=> (ramAddr[WORD_W-1:0] == WORD_W'($past(ramAddr[WORD_W-1:0]) + 1'b1)));

  p_done_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> done);

  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (start && busy && dbgState != 3'd5) |=> busy);

endmodule

bind pack_archiver pack_archiver_chk #(
  .ADDR_W (ADDR_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .seekStart (seekStart),
  .seekDone  (seekDone),
  .rdStart   (rdStart),
  .rdDone    (rdDone),
  .ramWe     (ramWe),
  .ramAddr   (ramAddr),
  .dbgState  (dbgState)
);

// File: tb/tb_pack_archiver.sv
module tb_pack_archiver;

  localparam int NC = 3;
  localparam int NH = 2;
  localparam int NS = 3;
  localparam int W  = 4;
  localparam int TOTAL = NC * NH * NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic seekDone = 1'b0;
  logic rdDone = 1'b0;
  logic wordValid = 1'b0;
  logic [15:0] wordIn = '0;
  logic busy, done, seekStart, rdStart, ramWe;
  logic [1:0] seekCyl;
  logic [0:0] rdHead;
  logic [1:0] rdSect;
  logic [6:0] ramAddr;
  logic [15:0] ramData;
  logic [2:0] dbgState;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  pack_archiver #(.NUM_CYL(NC), .NUM_HEAD(NH), .NUM_SECT(NS), .WORDS(W), .DATA_W(16)) dut (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .seekStart(seekStart), .seekCyl(seekCyl), .seekDone(seekDone),
    .rdStart(rdStart), .rdHead(rdHead), .rdSect(rdSect), .rdDone(rdDone),
    .wordValid(wordValid), .wordIn(wordIn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramData(ramData), .dbgState(dbgState)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expSect(input int n); return n % NS; endfunction
  function automatic int expHead(input int n); return (n / NS) % NH; endfunction
  function automatic int expCyl(input int n);  return n / (NS * NH); endfunction
  function automatic int expAddr(input int serial, input int idx); return serial * W + idx; endfunction

  task automatic checkResetState();
    check(dbgState == 3'd0, "R1 state", int'(dbgState), 0);
    check(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    check(!seekStart && !rdStart, "R1 requests", int'({seekStart, rdStart}), 0);
    check(seekCyl == 0 && rdHead == 0 && rdSect == 0, "R1 counters",
          int'({seekCyl, rdHead, rdSect}), 0);
    check(ramAddr == 0, "R1 address", int'(ramAddr), 0);
  endtask

  // mode 1: full sectors, completion together with the final word
  task automatic runCart(input int mode, input int abortAt);
    int n = 0, nSeek = 0, wIdx = 0, wordsLeft = 0, seekCnt = 0, rdCnt = 0;
    int cyc = 0, stored = 0;
    bit pSeekStart = 0, pSeekDone = 0, pRdStart = 0, pRdDone = 0, pStart = 0, pBusy = 0;
    @(negedge clk);
    start = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 5000) begin
        check(1'b0, "R9 run did not finish", cyc, 5000);
        start = 1'b0;
        return;
      end
      if (cyc == 1) begin
        check(busy, "R2 busy after start", int'(busy), 1);
        check(!done, "R2 done cleared", int'(done), 0);
        check(seekStart && seekCyl == 0, "R2 first seek", int'({seekStart, seekCyl}), 4);
        check(ramAddr == 0, "R2 address zero", int'(ramAddr), 0);
        start = 1'b0;
        pStart = 1'b0;
      end
      if (pSeekStart && pSeekDone) check(!seekStart, "R3 seek drop", int'(seekStart), 0);
      if (pSeekStart && !pSeekDone) check(seekStart, "R3 seek hold", int'(seekStart), 1);
      if (pRdStart && pRdDone) check(!rdStart, "R4 read drop", int'(rdStart), 0);
      if (pRdStart && !pRdDone) check(rdStart, "R4 read hold", int'(rdStart), 1);
      if (pStart && pBusy) check(busy, "R10 start while busy", int'(busy), 1);
      if (seekStart && !pSeekStart) begin
        check(int'(seekCyl) == nSeek && n == nSeek * NS * NH, "R6 seek on new cylinder",
              int'(seekCyl), nSeek);
        nSeek++;
        seekCnt = int'($urandom % 4);
      end
      if (rdStart && !pRdStart) begin
        check(!pSeekStart && !pSeekDone && !pRdDone, "R4 clean read start",
              int'({pSeekStart, pSeekDone, pRdDone}), 0);
        check(int'(rdSect) == expSect(n), "R5 sector order", int'(rdSect), expSect(n));
        check(int'(rdHead) == expHead(n), "R5 head order", int'(rdHead), expHead(n));
        check(int'(seekCyl) == expCyl(n), "R5 cylinder order", int'(seekCyl), expCyl(n));
        n++;
        wIdx = 0;
        wordsLeft = (mode == 1) ? W : 1 + int'($urandom % W);
      end
      if (abortAt > 0 && cyc == abortAt) begin
        rst = 1'b1; seekDone = 1'b0; rdDone = 1'b0; wordValid = 1'b0; start = 1'b0;
        @(negedge clk);
        checkResetState();
        rst = 1'b0;
        return;
      end
      if (cyc > 1 && !busy) begin
        start = 1'b0;
        wordValid = 1'b0;
        check(done, "R9 done at end", int'(done), 1);
        check(n == TOTAL, "R5 all sectors read", n, TOTAL);
        check(nSeek == NC, "R6 one seek per cylinder", nSeek, NC);
        if (mode == 1) check(stored == TOTAL * W, "R8 word count", stored, TOTAL * W);
        repeat (3) @(negedge clk);
        check(done && !busy, "R9 done holds", int'({done, busy}), 2);
        return;
      end
      // positioning engine model
      if (seekStart && !seekDone) begin
        if (seekCnt == 0) begin seekDone = 1'b1; seekCnt = int'($urandom % 3); end
        else seekCnt--;
      end else if (!seekStart && seekDone) begin
        if (seekCnt == 0) seekDone = 1'b0; else seekCnt--;
      end
      // read engine model
      wordValid = 1'b0;
      if (rdStart && !rdDone) begin
        if (wordsLeft > 0 && (mode == 1 || $urandom % 2 == 0)) begin
          wordValid = 1'b1;
          wordIn = 16'($urandom);
          wordsLeft--;
          if (wordsLeft == 0 && (mode == 1 || $urandom % 2 == 0)) begin
            rdDone = 1'b1; rdCnt = int'($urandom % 3);
          end
        end else if (wordsLeft == 0) begin
          rdDone = 1'b1; rdCnt = int'($urandom % 3);
        end
      end else if (!rdStart && rdDone) begin
        if (rdCnt == 0) rdDone = 1'b0; else rdCnt--;
      end else if (!rdStart && $urandom % 8 == 0) begin
        wordValid = 1'b1;  // stray word outside a read
        wordIn = 16'($urandom);
      end
      if (cyc > 1) start = (dbgState != 3'd5) && ($urandom % 16 == 0);
      #1;
      check(ramWe == (wordValid && rdStart), "R7 write enable",
            int'(ramWe), int'(wordValid && rdStart));
      if (wordValid && rdStart) begin
        check(int'(ramAddr) == expAddr(n - 1, wIdx), "R8 address",
              int'(ramAddr), expAddr(n - 1, wIdx));
        check(ramData == wordIn, "R7 data", int'(ramData), int'(wordIn));
        wIdx++;
        stored++;
      end
      pSeekStart = seekStart; pSeekDone = seekDone;
      pRdStart = rdStart; pRdDone = rdDone;
      pStart = start; pBusy = busy;
    end
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    checkResetState();
    rst = 1'b0;
    runCart(1, 0);
    runCart(0, 0);
    runCart(0, 120);
    runCart(0, 0);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule